// File: doc/BRIEF.md
# SAR converter acquisition sequencer

This block is the host side of a serial successive-approximation converter. It starts one conversion per programmable sample period by pulsing the convert strobe. It then waits for the conversion to end. End of conversion is either a fixed count of clocks or, in busy-indicator mode, the falling edge of the converter's serial output. After that it runs one SPI exchange with the clock idling high (CPOL = 1, CPHA = 1). That exchange shifts the 14-bit configuration word out while the 14-bit result of an earlier conversion shifts in.

The converter applies a configuration two phases after the configuration is written, and its first results after power-up carry no meaning. The sequencer therefore sends the configuration on every exchange, including the start-up ones. It drops the first three results after reset. Each result it keeps goes out with a single-cycle strobe and the configuration word that produced it. Each exchange has enough falling SCK edges to release the serial output, with a longer count when configuration readback is on. A zero on either timing input selects the built-in default: a 500-clock period (250 kSPS at 125 MHz) and a 290-clock conversion wait.

Top module: `sar_acq_seq`

## Requirements
- R1: While reset is held and on the first cycle after it, `cnv` is 0, `sck` is 1 and `sample_valid` is 0.
- R2: Successive rising edges of `cnv` are `cycle_period` clocks apart, with the period taken when `cnv` rises. `cnv` stays high for more than one clock.
- R3: A `cycle_period` of 0 gives a 500-clock period, and a `conv_wait` of 0 gives a 290-clock conversion wait.
- R4: With `busy_mode` = 0, the first falling SCK edge of a phase comes exactly `conv_wait` + 2 clocks after `cnv` rises.
- R5: With `busy_mode` = 1, SCK stays high until `sdo` falls after `cnv` rises, and `cnv` is low when `sdo` falls.
- R6: SCK idles high. `din` changes on falling SCK edges and `sdo` is sampled on rising edges. The configuration word goes out MSB first on falling edges 1 to 14, and `cnv` never rises during an exchange.
- R7: Each exchange has exactly 15 falling SCK edges when `readback_en` = 0, or 29 when it is 1.
- R8: The result is the 14 bits sampled on rising SCK edges 1 to 14, MSB first. `sample_valid` is high for exactly one clock per kept result.
- R9: The results of the first three exchanges after reset are dropped, and every later exchange yields one strobe.
- R10: `sample_cfg` equals the configuration word sent two exchanges before the exchange that read the result.
- R11: The configuration word sampled when `cnv` rises is the one sent in that phase, including during the start-up phases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cycle_period | input | 16 | Clocks between conversion starts, 0 selects the default |
| conv_wait | input | 16 | Clocks from conversion start to the exchange, 0 selects the default |
| busy_mode | input | 1 | 1: wait for the falling edge of `sdo` instead of counting |
| readback_en | input | 1 | 1: 29-edge exchange, 0: 15-edge exchange |
| cfg_word | input | 14 | Configuration word to send |
| sdo | input | 1 | Serial data from the converter |
| cnv | output | 1 | Convert strobe |
| sck | output | 1 | Serial clock, idles high |
| din | output | 1 | Serial data to the converter |
| sample_data | output | 14 | Kept conversion result |
| sample_cfg | output | 14 | Configuration that produced the result |
| sample_valid | output | 1 | One-cycle strobe for a kept result |

## Verification
The bench models the converter, including its two-phase configuration lag and its busy edge on the serial output. Phases draw random periods, waits, configuration words, end-of-conversion modes and exchange lengths. Phases in busy mode show whether the exchange waits for the serial edge, and counted phases show whether it starts after the exact wait. The two exchange lengths tell the 15-edge count from the 29-edge count. Changing the configuration word every phase shows whether the tag lags by exactly two exchanges. A closing run with zero timing inputs checks the defaults, and the first exchanges after reset check the discard.

// File: rtl/sar_acq_pkg.sv
package sar_acq_pkg;
    localparam int RES_W          = 14;
    localparam int CNT_W          = 16;
    localparam int EDGE_W         = 6;
    localparam int EDGES_PLAIN    = 15;
    localparam int EDGES_READBACK = 29;

    typedef enum logic [1:0] {PH_GAP, PH_CNV, PH_CONV, PH_XFER} phase_e;

    typedef struct packed {
        logic [RES_W-1:0] data;
        logic [RES_W-1:0] cfg;
    } sample_t;

    function automatic logic [CNT_W-1:0] pick_count(input logic [CNT_W-1:0] req,
                                                    input logic [CNT_W-1:0] dflt);
        return (req == '0) ? dflt : req;
    endfunction

    function automatic logic [EDGE_W-1:0] edge_total(input logic readback);
        return readback ? EDGE_W'(EDGES_READBACK) : EDGE_W'(EDGES_PLAIN);
    endfunction
endpackage

// File: rtl/sar_spi_m3.sv
module sar_spi_m3 #(
    parameter int DW     = 14,
    parameter int HALF   = 2,
    parameter int EDGE_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [DW-1:0]     tx_word,
    input  logic [EDGE_W-1:0] n_edges,
    input  logic              sdo,
    output logic              sck,
    output logic              din,
    output logic [DW-1:0]     rx_word,
    output logic              done
);
    localparam int DIV_W = (HALF > 1) ? $clog2(HALF) : 1;

    logic              active;
    logic [DIV_W-1:0]  div;
    logic [EDGE_W-1:0] falls;
    logic [DW-1:0]     tx_sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            active  <= 1'b0;
            div     <= '0;
            falls   <= '0;
            tx_sh   <= '0;
            rx_word <= '0;
            sck     <= 1'b1;
            din     <= 1'b0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                active <= 1'b1;
                div    <= '0;
                falls  <= '0;
                tx_sh  <= tx_word;
                din    <= 1'b0;
                sck    <= 1'b1;
            end else if (active) begin
                if (div == DIV_W'(HALF - 1)) begin
                    div <= '0;
                    if (sck) begin
                        sck   <= 1'b0;
                        din   <= tx_sh[DW-1];
                        tx_sh <= {tx_sh[DW-2:0], 1'b0};
                        falls <= falls + 1'b1;
                    end else begin
                        sck <= 1'b1;
                        if (falls <= EDGE_W'(DW))
                            rx_word <= {rx_word[DW-2:0], sdo};
                        if (falls == n_edges) begin
                            active <= 1'b0;
                            done   <= 1'b1;
                        end
                    end
                end else begin
                    div <= div + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/sar_cfg_lag.sv
module sar_cfg_lag #(
    parameter int W     = 14,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage [DEPTH];

    always_ff @(posedge clk) begin
        if (rst)       stage[0] <= '0;
        else if (push) stage[0] <= din;
    end

    for (genvar i = 1; i < DEPTH; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst)       stage[i] <= '0;
            else if (push) stage[i] <= stage[i-1];
        end
    end

    assign dout = stage[DEPTH-1];
endmodule

// File: rtl/sar_acq_seq.sv
module sar_acq_seq
    import sar_acq_pkg::*;
#(
    parameter int DW         = RES_W,
    parameter int CNV_CLKS   = 4,
    parameter int SCK_HALF   = 2,
    parameter int DISCARD    = 3,
    parameter int CFG_LAG    = 2,
    parameter int DEF_PERIOD = 500,
    parameter int DEF_CONV   = 290
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] cycle_period,
    input  logic [CNT_W-1:0] conv_wait,
    input  logic             busy_mode,
    input  logic             readback_en,
    input  logic [DW-1:0]    cfg_word,
    input  logic             sdo,
    output logic             cnv,
    output logic             sck,
    output logic             din,
    output logic [DW-1:0]    sample_data,
    output logic [DW-1:0]    sample_cfg,
    output logic             sample_valid
);
    localparam int DISC_W = $clog2(DISCARD + 1);
    localparam int CW1    = CNT_W + 1;

    phase_e            st;
    logic [CNT_W-1:0]  phase_cnt, per_l, conv_l;
    logic              busy_l, rb_l, sdo_q, sdo_qq;
    logic [DW-1:0]     cfg_l, rx_word, tag_word;
    logic [DISC_W-1:0] disc_cnt;
    logic              spi_done, spi_start, period_up, conv_up, xfer_act;
    sample_t           smp;

    assign period_up = ({1'b0, phase_cnt} + CW1'(1)) >= {1'b0, per_l};
    assign conv_up   = busy_l ? (sdo_qq & ~sdo_q)
                              : (({1'b0, phase_cnt} + CW1'(1)) >= {1'b0, conv_l});
    assign spi_start = (st == PH_CONV) && conv_up;
    assign xfer_act  = (st == PH_XFER);
    assign cnv       = (st == PH_CNV);

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= PH_GAP;
            phase_cnt <= '0;
            per_l     <= '0;
            conv_l    <= '0;
            busy_l    <= 1'b0;
            rb_l      <= 1'b0;
            cfg_l     <= '0;
            sdo_q     <= 1'b0;
            sdo_qq    <= 1'b0;
        end else begin
            sdo_q  <= sdo;
            sdo_qq <= sdo_q;
            if (phase_cnt != '1) phase_cnt <= phase_cnt + 1'b1;
            case (st)
                PH_GAP: if (period_up) begin
                    st        <= PH_CNV;
                    phase_cnt <= '0;
                    per_l     <= pick_count(cycle_period, CNT_W'(DEF_PERIOD));
                    conv_l    <= pick_count(conv_wait, CNT_W'(DEF_CONV));
                    busy_l    <= busy_mode;
                    rb_l      <= readback_en;
                    cfg_l     <= cfg_word;
                end
                PH_CNV:  if (phase_cnt == CNT_W'(CNV_CLKS - 1)) st <= PH_CONV;
                PH_CONV: if (conv_up) st <= PH_XFER;
                PH_XFER: if (spi_done) st <= PH_GAP;
                default: st <= PH_GAP;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            disc_cnt     <= '0;
            sample_valid <= 1'b0;
            smp          <= '0;
        end else begin
            sample_valid <= 1'b0;
            if (spi_done) begin
                if (disc_cnt == DISC_W'(DISCARD)) begin
                    sample_valid <= 1'b1;
                    smp.data     <= rx_word;
                    smp.cfg      <= tag_word;
                end else begin
                    disc_cnt <= disc_cnt + 1'b1;
                end
            end
        end
    end

    assign sample_data = smp.data;
    assign sample_cfg  = smp.cfg;

    sar_spi_m3 #(.DW(DW), .HALF(SCK_HALF), .EDGE_W(EDGE_W)) u_spi (
        .clk(clk), .rst(rst), .start(spi_start), .tx_word(cfg_l),
        .n_edges(edge_total(rb_l)), .sdo(sdo), .sck(sck), .din(din),
        .rx_word(rx_word), .done(spi_done)
    );

    sar_cfg_lag #(.W(DW), .DEPTH(CFG_LAG)) u_lag (
        .clk(clk), .rst(rst), .push(spi_done), .din(cfg_l), .dout(tag_word)
    );
endmodule

// File: rtl/sar_acq_seq_chk.sv
module sar_acq_seq_chk #(
    parameter int DISCARD = 3
) (
    input logic clk,
    input logic rst,
    input logic cnv,
    input logic sck,
    input logic sample_valid,
    input logic xfer_act
);
    logic       cnv_d;
    logic [7:0] rises;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnv_d <= 1'b0;
            rises <= '0;
        end else begin
            cnv_d <= cnv;
            if (cnv && !cnv_d && rises != 8'hFF) rises <= rises + 1'b1;
        end
    end

    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!cnv && sck && !sample_valid));
    assert_cnv_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(cnv) |=> cnv);
    assert_sck_idle_R6: assert property (@(posedge clk) disable iff (rst)
        !xfer_act |-> sck);
    assert_cnv_quiet_xfer_R6: assert property (@(posedge clk) disable iff (rst)
        xfer_act |-> !cnv);
    assert_valid_single_R8: assert property (@(posedge clk) disable iff (rst)
        sample_valid |=> !sample_valid);
    assert_discard_R9: assert property (@(posedge clk) disable iff (rst)
        sample_valid |-> (rises > 8'(DISCARD)));
endmodule

bind sar_acq_seq sar_acq_seq_chk #(.DISCARD(DISCARD)) u_chk (
    .clk(clk), .rst(rst), .cnv(cnv), .sck(sck),
    .sample_valid(sample_valid), .xfer_act(xfer_act)
);

// File: tb/sar_acq_seq_bench.sv
`timescale 1ns/1ps
module sar_acq_seq_bench;
    localparam int W     = 14;
    localparam int HALF  = 2;
    localparam int TCONV = 40;
    localparam int NPH   = 33;
    localparam int LIMIT = 100000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [15:0] cycle_period, conv_wait;
    logic busy_mode, readback_en, sdo_m;
    logic [W-1:0] cfg_word;
    logic cnv, sck, din, sample_valid;
    logic [W-1:0] sample_data, sample_cfg;

    always #4 clk = ~clk;

    sar_acq_seq u_sar_acq_seq (
        .clk(clk), .rst(rst), .cycle_period(cycle_period), .conv_wait(conv_wait),
        .busy_mode(busy_mode), .readback_en(readback_en), .cfg_word(cfg_word),
        .sdo(sdo_m), .cnv(cnv), .sck(sck), .din(din), .sample_data(sample_data),
        .sample_cfg(sample_cfg), .sample_valid(sample_valid)
    );

    int checks = 0, errs = 0, cyc = 0, kidx = -1, rise_cyc = 0, edges = 0;
    int eoc_cnt = 0, nval = 0;
    bit done_flag = 0, eoc_seen = 0, cnv_p = 0, sck_p = 1, valid_p = 0;
    logic [15:0] cur_per, cur_conv;
    logic cur_busy, cur_rb;
    logic [W-1:0] cur_cfg, rx_w, last_w, staged, active;
    logic [W-1:0] res_arr [0:63];
    logic [W-1:0] word_hist [0:63];

    function automatic int eff(input logic [15:0] v, input int d);
        return (v == 0) ? d : int'(v);
    endfunction
    function automatic int exp_edges(input logic rb);
        return rb ? 29 : 15;
    endfunction
    function automatic logic [W-1:0] conv_result(input logic [W-1:0] c, input int k);
        return W'(c ^ W'(k * 37 + 5));
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic new_inputs(input int next_phase);
        if (next_phase >= NPH - 3) begin
            cycle_period = 16'd0;
            conv_wait    = 16'd0;
            busy_mode    = 1'b0;
        end else begin
            cycle_period = 16'(200 + $urandom % 61);
            conv_wait    = 16'(42 + $urandom % 20);
            busy_mode    = 1'($urandom % 2);
        end
        readback_en = 1'($urandom % 2);
        cfg_word    = W'($urandom);
    endtask

    task automatic on_cnv_rise();
        if (kidx >= 0) begin
            chk(edges == exp_edges(cur_rb), "R7 falling edge count", edges, exp_edges(cur_rb));
            chk(rx_w == cur_cfg, "R6/R11 config word on din", int'(rx_w), int'(cur_cfg));
            chk(cyc - rise_cyc == eff(cur_per, 500), "R2/R3 conversion period",
                cyc - rise_cyc, eff(cur_per, 500));
            word_hist[kidx] = rx_w;
            last_w = rx_w;
        end
        kidx++;
        if (kidx == NPH) begin
            chk(nval == NPH - 3, "R9 kept sample count", nval, NPH - 3);
            done_flag = 1;
        end
        active = staged;
        staged = last_w;
        res_arr[kidx % 64] = conv_result(active, kidx);
        cur_per = cycle_period; cur_conv = conv_wait; cur_busy = busy_mode;
        cur_rb = readback_en; cur_cfg = cfg_word;
        rise_cyc = cyc; edges = 0; rx_w = '0;
        eoc_cnt = TCONV; eoc_seen = 0; sdo_m = 1'b1;
        new_inputs(kidx + 1);
    endtask

    task automatic on_sck_fall();
        edges++;
        if (edges == 1) begin
            if (cur_busy) begin
                chk(eoc_seen, "R5 SCK held until sdo falls", int'(eoc_seen), 1);
            end else begin
                chk(cyc - rise_cyc == eff(cur_conv, 290) + HALF, "R4 counted wait",
                    cyc - rise_cyc, eff(cur_conv, 290) + HALF);
            end
        end
        if (edges <= W) sdo_m = res_arr[kidx % 64][W - edges];
        else if (edges <= 2 * W) sdo_m = active[2 * W - edges];
    endtask

    task automatic on_valid();
        nval++;
        chk(kidx >= 3, "R9 no strobe in first three exchanges", kidx, 3);
        chk(sample_data == res_arr[kidx % 64], "R8 sample data",
            int'(sample_data), int'(res_arr[kidx % 64]));
        if (kidx >= 2)
            chk(sample_cfg == word_hist[kidx - 2], "R10 configuration tag",
                int'(sample_cfg), int'(word_hist[kidx - 2]));
    endtask

    task automatic step();
        @(negedge clk);
        cyc++;
        if (cnv && !cnv_p) on_cnv_rise();
        if (eoc_cnt > 0) begin
            eoc_cnt--;
            if (eoc_cnt == 0) begin
                sdo_m = 1'b0;
                eoc_seen = 1;
                if (cur_busy) chk(cnv == 1'b0, "R5 cnv low at end of conversion", int'(cnv), 0);
            end
        end
        if (!sck && sck_p) on_sck_fall();
        if (sck && !sck_p && edges <= W) rx_w = {rx_w[W-2:0], din};
        if (sample_valid) on_valid();
        if (sample_valid && valid_p) chk(0, "R8 strobe width", 2, 1);
        cnv_p = cnv; sck_p = sck; valid_p = sample_valid;
    endtask

    initial begin
        void'($urandom(32'd7));
        sdo_m = 1'b0; staged = '0; active = '0; last_w = '0; rx_w = '0;
        cycle_period = 16'd220; conv_wait = 16'd50; busy_mode = 1'b0;
        readback_en = 1'b0; cfg_word = 14'h2A5A;
        cur_per = '0; cur_conv = '0; cur_busy = 0; cur_rb = 0; cur_cfg = '0;
        repeat (4) @(negedge clk);
        chk(cnv == 1'b0 && sck == 1'b1 && sample_valid == 1'b0, "R1 reset outputs",
            int'({cnv, sck, sample_valid}), 3'b010);
        rst = 1'b0;
        while (!done_flag && cyc < LIMIT) step();
        if (!done_flag) chk(0, "watchdog expired", cyc, LIMIT);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule